// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits at the head of a receive path and decides, from the first six bytes of a frame (the destination MAC address), whether the frame should be kept. The bytes arrive one per cycle when `byte_valid` is high, with idle cycles allowed between them. A single-cycle start-of-frame pulse restarts the filter, so every frame is judged on its own bytes only. Frame storage and payload CRC checking belong to other blocks.

The verdict combines the station's own address, a 64-bit multicast hash table and three receive-mode enables. A promiscuous setting keeps everything. An all-ones destination is a broadcast and is gated by its own enable. Any other address with the group bit set is a multicast, which needs the multicast enable and a set bit in the hash table at a position derived from a CRC of the address. All remaining addresses are unicast and must equal the station address exactly. A registered strobe carries the verdict together with a flag that marks multicast destinations.

Top module: `eth_dest_filter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `dec_valid`, `dec_accept` and `dec_mcast` are 0.
- R2: `dec_valid` is high for exactly one cycle: the cycle after the clock edge that takes the sixth destination byte of a frame, regardless of idle cycles between the bytes.
- R3: A frame that reaches fewer than six bytes before the next `sof` produces no strobe; bytes after the sixth are ignored until the next `sof`. A byte presented with `sof` high is byte 0 of the new frame.
- R4: With `cfg_promisc` = 1, every frame is accepted whatever its destination.
- R5: A destination whose six bytes are all 0xFF is accepted exactly when `cfg_bcast_en` = 1 (or promiscuous), independent of the multicast enable and the hash table.
- R6: A destination that is not all-ones and has bit 0 of byte 0 set is a multicast; it is rejected when `cfg_mcast_en` = 0 and promiscuous mode is off.
- R7: An enabled multicast is accepted exactly when `hash_table[idx]` is 1 (table byte idx/8, bit idx%8). idx is bits 31..26 of a 32-bit CRC with polynomial 0x04C11DB7 and initial value all ones, fed the 48 address bits byte 0 first, each byte least significant bit first, where each step XORs the polynomial into the left-shifted register when the old bit 31 differs from the input bit.
- R8: Any other destination is unicast and is accepted exactly when each byte k (k = 0 first received) equals `station_addr[8k+7:8k]`.
- R9: `dec_mcast` is 1 with the strobe exactly when the destination is a multicast as defined in R6; outside the strobe cycle `dec_accept` and `dec_mcast` are 0.
- R10: The mode enables, `station_addr` and `hash_table` are taken as they are in the cycle the sixth byte is presented; their values during earlier bytes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse; restarts the filter |
| byte_valid | input | 1 | `byte_data` carries a frame byte this cycle |
| byte_data | input | 8 | Received byte |
| station_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| hash_table | input | 64 | Multicast hash table, bit n for hash index n |
| cfg_promisc | input | 1 | Accept all frames |
| cfg_bcast_en | input | 1 | Accept broadcast frames |
| cfg_mcast_en | input | 1 | Allow multicast frames through the hash test |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Frame accepted (valid with strobe) |
| dec_mcast | output | 1 | Destination is multicast (valid with strobe) |

## Verification
The bound checker follows the byte count independently and confirms on every cycle that the strobe appears exactly after a sixth byte and never otherwise, that it lasts one cycle, that the verdict outputs stay quiet between strobes, that promiscuous mode always accepts and that a multicast with the enable off is refused. Whether a given address is classed correctly, the CRC-derived table position, the exact unicast compare, the broadcast gate and the sampling instant of the configuration can only be shown by the bench's scenarios, which pick addresses and table contents and compare against a model built from the requirements.

// File: rtl/daf_pkg.sv
// Shared constants and types for the destination address filter.
// Assumes a standard 32-bit Ethernet CRC generator polynomial.
package daf_pkg;

    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    // Class of a destination address.
    typedef enum logic [1:0] {
        DST_UNICAST   = 2'd0,
        DST_MULTICAST = 2'd1,
        DST_BROADCAST = 2'd2
    } dst_kind_e;

    // Advance the CRC register by one input bit.
    function automatic logic [31:0] crc_bit_step(input logic [31:0] c, input logic din);
        logic fb;
        fb = c[31] ^ din;
        return {c[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    endfunction

endpackage

// File: rtl/daf_crc_hash.sv
// Running CRC over the destination bytes, least significant bit first.
// Presents the hash index including the byte offered this cycle, so the
// top level can decide on the same edge that takes the last byte.
// Assumes clear and step may be high together (first byte of a frame).
module daf_crc_hash #(
    parameter int BYTE_W     = 8,
    parameter int HASH_IDX_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  step,
    input  logic [BYTE_W-1:0]     data,
    output logic [HASH_IDX_W-1:0] idx_next
);
    import daf_pkg::*;

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_base;
    logic [CRC_W-1:0] crc_stepped;
    logic [CRC_W-1:0] crc_nxt;

    // Fold the whole byte into the register, bit 0 first.
    always_comb begin
        crc_base    = clear ? CRC_SEED : crc_q;
        crc_stepped = crc_base;
        for (int i = 0; i < BYTE_W; i++) begin
            crc_stepped = crc_bit_step(crc_stepped, data[i]);
        end
        crc_nxt = step ? crc_stepped : crc_base;
    end

    // Hold the running CRC between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= CRC_SEED;
        else        crc_q <= crc_nxt;
    end

    assign idx_next = crc_nxt[CRC_W-1 -: HASH_IDX_W];

endmodule

// File: rtl/daf_addr_match.sv
// Byte-wise accumulators for the exact station compare, the all-ones
// (broadcast) test and the group bit of byte 0. Outputs include the byte
// offered this cycle. Assumes byte_sel is in range whenever step is high.
module daf_addr_match #(
    parameter int ADDR_BYTES = 6,
    parameter int BYTE_W     = 8,
    parameter int SEL_W      = 3,
    localparam int ADDR_W    = ADDR_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [SEL_W-1:0]  byte_sel,
    input  logic [BYTE_W-1:0] data,
    input  logic [ADDR_W-1:0] station,
    output logic              match_next,
    output logic              ones_next,
    output logic              group_next
);
    logic              match_q, ones_q, group_q;
    logic              match_b, ones_b, group_b;
    logic [BYTE_W-1:0] station_byte;

    // Pick the station byte that lines up with the incoming one.
    always_comb begin
        station_byte = '0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (int'(byte_sel) == k) station_byte = station[k*BYTE_W +: BYTE_W];
        end
    end

    // Combine stored flags with the current byte.
    always_comb begin
        match_b    = clear ? 1'b1 : match_q;
        ones_b     = clear ? 1'b1 : ones_q;
        group_b    = clear ? 1'b0 : group_q;
        match_next = match_b;
        ones_next  = ones_b;
        group_next = group_b;
        if (step) begin
            match_next = match_b & (data == station_byte);
            ones_next  = ones_b & (&data);
            if (byte_sel == '0) group_next = data[0];
        end
    end

    // Hold the flags between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b1;
            ones_q  <= 1'b1;
            group_q <= 1'b0;
        end else begin
            match_q <= match_next;
            ones_q  <= ones_next;
            group_q <= group_next;
        end
    end

endmodule

// File: rtl/daf_decide.sv
// Pure combinational verdict from the address class and the mode bits.
// Broadcast is tested before the general group-bit (multicast) path.
module daf_decide #(
    parameter int HASH_IDX_W = 6,
    localparam int TABLE_W   = 1 << HASH_IDX_W
) (
    input  logic                  all_ones,
    input  logic                  group,
    input  logic                  station_match,
    input  logic [HASH_IDX_W-1:0] hash_idx,
    input  logic [TABLE_W-1:0]    hash_table,
    input  logic                  promisc,
    input  logic                  bcast_en,
    input  logic                  mcast_en,
    output daf_pkg::dst_kind_e    kind,
    output logic                  accept
);
    import daf_pkg::*;

    logic hash_hit;

    // Look up the selected table bit.
    assign hash_hit = hash_table[hash_idx];

    // Classify the address, broadcast first.
    always_comb begin
        if (all_ones)   kind = DST_BROADCAST;
        else if (group) kind = DST_MULTICAST;
        else            kind = DST_UNICAST;
    end

    // Apply the enable that governs each class.
    always_comb begin
        unique case (kind)
            DST_BROADCAST: accept = bcast_en;
            DST_MULTICAST: accept = mcast_en & hash_hit;
            default:       accept = station_match;
        endcase
        if (promisc) accept = 1'b1;
    end

endmodule

// File: rtl/eth_dest_filter.sv
// Destination address filter top. Counts destination bytes from each
// start-of-frame pulse, feeds them to the CRC and compare units and
// registers a verdict on the edge that takes the last address byte.
// Assumes one byte per valid cycle; configuration is sampled at that edge.
module eth_dest_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int BYTE_W     = 8,
    parameter int HASH_IDX_W = 6,
    localparam int ADDR_W    = ADDR_BYTES * BYTE_W,
    localparam int TABLE_W   = 1 << HASH_IDX_W,
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof,
    input  logic               byte_valid,
    input  logic [BYTE_W-1:0]  byte_data,
    input  logic [ADDR_W-1:0]  station_addr,
    input  logic [TABLE_W-1:0] hash_table,
    input  logic               cfg_promisc,
    input  logic               cfg_bcast_en,
    input  logic               cfg_mcast_en,
    output logic               dec_valid,
    output logic               dec_accept,
    output logic               dec_mcast
);
    import daf_pkg::*;

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);
    localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(ADDR_BYTES);

    logic [CNT_W-1:0]      cnt_q;
    logic [CNT_W-1:0]      cnt_base;
    logic                  take;
    logic                  last;
    logic [HASH_IDX_W-1:0] idx_next;
    logic                  match_next, ones_next, group_next;
    dst_kind_e             kind;
    logic                  verdict;

    // Byte position within the address, restarted by sof.
    assign cnt_base = sof ? '0 : cnt_q;
    assign take     = byte_valid && (cnt_base < DONE_CNT);
    assign last     = take && (cnt_base == LAST_IDX);

    // Advance the byte position, saturating once the address is complete.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= DONE_CNT;
        else if (take) cnt_q <= cnt_base + 1'b1;
        else           cnt_q <= cnt_base;
    end

    daf_crc_hash #(
        .BYTE_W     (BYTE_W),
        .HASH_IDX_W (HASH_IDX_W)
    ) u_hash (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sof),
        .step     (take),
        .data     (byte_data),
        .idx_next (idx_next)
    );

    daf_addr_match #(
        .ADDR_BYTES (ADDR_BYTES),
        .BYTE_W     (BYTE_W),
        .SEL_W      (CNT_W)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (sof),
        .step       (take),
        .byte_sel   (cnt_base),
        .data       (byte_data),
        .station    (station_addr),
        .match_next (match_next),
        .ones_next  (ones_next),
        .group_next (group_next)
    );

    daf_decide #(
        .HASH_IDX_W (HASH_IDX_W)
    ) u_decide (
        .all_ones      (ones_next),
        .group         (group_next),
        .station_match (match_next),
        .hash_idx      (idx_next),
        .hash_table    (hash_table),
        .promisc       (cfg_promisc),
        .bcast_en      (cfg_bcast_en),
        .mcast_en      (cfg_mcast_en),
        .kind          (kind),
        .accept        (verdict)
    );

    // Register the verdict on the edge that takes the last address byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_mcast  <= 1'b0;
        end else begin
            dec_valid  <= last;
            dec_accept <= last & verdict;
            dec_mcast  <= last & (kind == DST_MULTICAST);
        end
    end

endmodule

// File: rtl/eth_dest_filter_checker.sv
// Protocol checker for the destination filter, bound to the top module.
// Keeps its own byte count to predict when a verdict is due.
module eth_dest_filter_checker #(
    parameter int ADDR_BYTES = 6
) (
    input logic clk,
    input logic rst_n,
    input logic sof,
    input logic byte_valid,
    input logic cfg_promisc,
    input logic cfg_mcast_en,
    input logic dec_valid,
    input logic dec_accept,
    input logic dec_mcast
);
    localparam int W = $clog2(ADDR_BYTES + 2);

    logic [W-1:0] seen_q;
    logic [W-1:0] seen_b;
    logic         due_q;

    assign seen_b = sof ? '0 : seen_q;

    // Independent count of bytes since the last sof, and the verdict-due flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= W'(ADDR_BYTES);
            due_q  <= 1'b0;
        end else begin
            if (byte_valid && seen_b < W'(ADDR_BYTES)) seen_q <= seen_b + 1'b1;
            else                                      seen_q <= seen_b;
            due_q <= byte_valid && (seen_b == W'(ADDR_BYTES - 1));
        end
    end

    // R2 / R3: strobe exactly after a sixth byte, never otherwise.
    assert_strobe_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid == due_q);

    // R2: the strobe lasts one cycle.
    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R9: verdict outputs are quiet between strobes.
    assert_quiet_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_accept && !dec_mcast));

    // R4: promiscuous mode accepts.
    assert_promisc_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(cfg_promisc)) |-> dec_accept);

    // R6: multicast refused when its enable is off.
    assert_mcast_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_mcast && !$past(cfg_promisc) && !$past(cfg_mcast_en)) |-> !dec_accept);

endmodule

bind eth_dest_filter eth_dest_filter_checker #(
    .ADDR_BYTES (ADDR_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof          (sof),
    .byte_valid   (byte_valid),
    .cfg_promisc  (cfg_promisc),
    .cfg_mcast_en (cfg_mcast_en),
    .dec_valid    (dec_valid),
    .dec_accept   (dec_accept),
    .dec_mcast    (dec_mcast)
);

// File: tb/eth_dest_filter_tb.sv
module eth_dest_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [47:0] station_addr = '0;
    logic [63:0] hash_table = '0;
    logic        cfg_promisc = 1'b0;
    logic        cfg_bcast_en = 1'b0;
    logic        cfg_mcast_en = 1'b0;
    logic        dec_valid, dec_accept, dec_mcast;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    eth_dest_filter u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sof          (sof),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .station_addr (station_addr),
        .hash_table   (hash_table),
        .cfg_promisc  (cfg_promisc),
        .cfg_bcast_en (cfg_bcast_en),
        .cfg_mcast_en (cfg_mcast_en),
        .dec_valid    (dec_valid),
        .dec_accept   (dec_accept),
        .dec_mcast    (dec_mcast)
    );

    function automatic logic [47:0] mac(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    // Hash index per R7.
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c;
        logic        t;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            t = c[31] ^ a[i];
            c = c << 1;
            if (t) c = c ^ 32'h04C1_1DB7;
        end
        return c[31:26];
    endfunction

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    // Present one byte for one clock edge; returns at the following negedge.
    task automatic put_byte(input logic [7:0] b, input logic s);
        sof = s; byte_valid = 1'b1; byte_data = b;
        @(negedge clk);
        sof = 1'b0; byte_valid = 1'b0;
    endtask

    task automatic send_dst(input logic [47:0] a);
        for (int k = 0; k < 6; k++) put_byte(a[8*k +: 8], k == 0);
    endtask

    // Check the strobe cycle, then that it drops.
    task automatic expect_dec(input string req, input logic acc, input logic mc);
        chk(req, "dec_valid", dec_valid, 1'b1);
        chk(req, "dec_accept", dec_accept, acc);
        chk(req, "dec_mcast", dec_mcast, mc);
        @(negedge clk);
        chk(req, "dec_valid drop", dec_valid, 1'b0);
    endtask

    task automatic test_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "dec_valid in reset", dec_valid, 1'b0);
        chk("R1", "dec_accept in reset", dec_accept, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "dec_valid after reset", dec_valid, 1'b0);
        chk("R1", "dec_mcast after reset", dec_mcast, 1'b0);
    endtask

    task automatic test_unicast;
        station_addr = mac(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56);
        cfg_promisc = 0; cfg_bcast_en = 1; cfg_mcast_en = 1; hash_table = '1;
        send_dst(station_addr);
        expect_dec("R8 exact", 1'b1, 1'b0);
        send_dst(mac(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h57));
        expect_dec("R8 last byte differs", 1'b0, 1'b0);
        send_dst(mac(8'h04, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56));
        expect_dec("R8 first byte differs", 1'b0, 1'b0);
    endtask

    task automatic test_broadcast;
        cfg_promisc = 0; cfg_bcast_en = 0; cfg_mcast_en = 1; hash_table = '1;
        send_dst('1);
        expect_dec("R5 bcast disabled", 1'b0, 1'b0);
        cfg_bcast_en = 1; cfg_mcast_en = 0; hash_table = '0;
        send_dst('1);
        expect_dec("R5 bcast enabled", 1'b1, 1'b0);
    endtask

    task automatic test_multicast;
        logic [47:0] m[2];
        logic [5:0]  ix;
        m[0] = mac(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01);
        m[1] = mac(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'hFB);
        cfg_promisc = 0; cfg_bcast_en = 1;
        for (int j = 0; j < 2; j++) begin
            ix = ref_idx(m[j]);
            cfg_mcast_en = 0; hash_table = '1;
            send_dst(m[j]);
            expect_dec("R6 mcast disabled", 1'b0, 1'b1);
            cfg_mcast_en = 1; hash_table = '0; hash_table[ix] = 1'b1;
            send_dst(m[j]);
            expect_dec("R7 hash bit set", 1'b1, 1'b1);
            hash_table = '1; hash_table[ix] = 1'b0;
            send_dst(m[j]);
            expect_dec("R7 hash bit clear", 1'b0, 1'b1);
        end
    endtask

    task automatic test_promisc;
        cfg_promisc = 1; cfg_bcast_en = 0; cfg_mcast_en = 0; hash_table = '0;
        send_dst(mac(8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F));
        expect_dec("R4 foreign unicast", 1'b1, 1'b0);
        send_dst(mac(8'h01, 8'h00, 8'h5E, 8'h7F, 8'h00, 8'h02));
        expect_dec("R4 multicast", 1'b1, 1'b1);
        send_dst('1);
        expect_dec("R4 broadcast", 1'b1, 1'b0);
        cfg_promisc = 0;
    endtask

    task automatic test_short_frame;
        cfg_bcast_en = 1;
        for (int k = 0; k < 4; k++) put_byte(8'hFF, k == 0);
        for (int w = 0; w < 3; w++) begin
            chk("R3", "no strobe on short frame", dec_valid, 1'b0);
            @(negedge clk);
        end
        send_dst(station_addr);
        expect_dec("R3 frame after short one", 1'b1, 1'b0);
    endtask

    task automatic test_gaps;
        logic [47:0] a;
        a = station_addr;
        for (int k = 0; k < 6; k++) begin
            put_byte(a[8*k +: 8], k == 0);
            if (k < 5) begin
                repeat (2) begin
                    chk("R2", "no early strobe", dec_valid, 1'b0);
                    @(negedge clk);
                end
            end
        end
        expect_dec("R2 gapped bytes", 1'b1, 1'b0);
    endtask

    task automatic test_extra_bytes;
        send_dst(station_addr);
        expect_dec("R3 base frame", 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) begin
            put_byte(8'h5A, 1'b0);
            chk("R3", "trailing byte ignored", dec_valid, 1'b0);
        end
    endtask

    task automatic test_sampling;
        cfg_promisc = 0; cfg_bcast_en = 0;
        for (int k = 0; k < 5; k++) put_byte(8'hFF, k == 0);
        cfg_bcast_en = 1;
        put_byte(8'hFF, 1'b0);
        cfg_bcast_en = 0;
        expect_dec("R10 enable set at sixth byte", 1'b1, 1'b0);
        cfg_bcast_en = 1;
        for (int k = 0; k < 5; k++) put_byte(8'hFF, k == 0);
        cfg_bcast_en = 0;
        put_byte(8'hFF, 1'b0);
        cfg_bcast_en = 1;
        expect_dec("R10 enable cleared at sixth byte", 1'b0, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_unicast();
        test_broadcast();
        test_multicast();
        test_promisc();
        test_short_frame();
        test_gaps();
        test_extra_bytes();
        test_sampling();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule